// File: doc/BRIEF.md
# Multi-Context Reservation Monitor

This block tracks address reservations for a set of hardware thread contexts so that they can run load-locked / store-conditional sequences against a shared memory. Each context owns one reservation: a valid flag and the physical address captured by its last locked load. A conditional store from a context succeeds only if that context still holds a reservation on the same 16-byte granule. Ordinary stores, and conditional stores that succeed, wipe every reservation on the granule they write. The memory data path and address translation are outside the block. Only the reservation decision is made here.

Requests arrive one per cycle on a single port. Each carries a context number, a physical address and three qualifiers: store versus load, locked, and uncacheable. The block returns a registered pass/fail result for every cacheable conditional store. It also keeps a count of back-to-back conditional-store failures for each context. When a context's count reaches a whole multiple of a fixed period, the block raises a one-cycle warning that names the context. This lets software or a debug agent spot a context that is likely livelocked.

Top module: `resv_monitor`

## Requirements
- R1: After synchronous reset, no context holds a reservation, every failure count is zero, and `res_valid`, `res_success` and `warn_pulse` are low.
- R2: A locked load (`req_store`=0, `req_locked`=1) sets the issuing context's reservation flag and captures `req_addr`. It produces no result.
- R3: A cacheable conditional store (`req_store`=1, `req_locked`=1, `req_uncached`=0) raises `res_valid` in the following cycle. `res_success` is 1 exactly when the issuer's flag was set and the stored address bits [ADDR_W-1:GRAN] equal those of the request (GRAN=4, so a 16-byte granule).
- R4: A failing conditional store clears only the issuer's reservation flag. Every other context's reservation is left unchanged.
- R5: A successful conditional store, and an ordinary store (`req_store`=1, `req_locked`=0), clear the flag of every context whose reserved granule matches the store's granule, including the issuer's.
- R6: An uncacheable conditional store (`req_store`=1, `req_locked`=1, `req_uncached`=1) makes no reservation check and leaves `res_valid` low. It resets the issuer's failure count and clears matching reservations, as a store does.
- R7: Each failing cacheable conditional store increments the issuer's failure count, and a success resets it. In the cycle after the failure that brings the count to a nonzero multiple of WARN_PERIOD, `warn_pulse` is high for one cycle and `warn_ctx` carries the issuer.
- R8: Ordinary loads (`req_store`=0, `req_locked`=0) and cycles with `req_valid` low change no reservation or count and produce no result.
- R9: Failure counts are kept per context. Another context's failures, successes or uncacheable stores do not advance or reset them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_ctx | input | $clog2(NUM_CTX) | Issuing context |
| req_addr | input | ADDR_W | Physical address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_locked | input | 1 | Locked load / conditional store qualifier |
| req_uncached | input | 1 | Uncacheable qualifier |
| res_valid | output | 1 | Conditional-store result present |
| res_success | output | 1 | Conditional store succeeded |
| warn_pulse | output | 1 | Failure-streak warning, one cycle |
| warn_ctx | output | $clog2(NUM_CTX) | Context that raised the warning |

## Verification
The hardest condition to reach from the ports is the warning. With the default period of 100000, it needs a long unbroken run of failures from one context. The bench therefore sets WARN_PERIOD to 6 and hammers one context with failing conditional stores until the count wraps at least twice. Other contexts' failures are interleaved to show the counts stay separate, and an uncacheable conditional store is placed mid-streak to show that it restarts the count. Cross-context clearing is reached by placing reservations from several contexts in the same granule and in neighbouring granules, then storing from a third context.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_LOCK,
    OP_STORE,
    OP_SC,
    OP_SC_UC
  } resv_op_e;
endpackage

// File: rtl/resv_decode.sv
module resv_decode
  import resv_pkg::*;
(
  input  logic     valid,
  input  logic     store,
  input  logic     locked,
  input  logic     uncached,
  output resv_op_e op
);
  always_comb begin
    if (!valid)                     op = OP_IDLE;
    else if (!store && !locked)     op = OP_LOAD;
    else if (!store)                op = OP_LOCK;
    else if (!locked)               op = OP_STORE;
    else if (uncached)              op = OP_SC_UC;
    else                            op = OP_SC;
  end
endmodule

// File: rtl/resv_slot.sv
module resv_slot
  import resv_pkg::*;
#(
  parameter int GRAN_HI = 28,
  parameter int PERIOD  = 100000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  resv_op_e           op,
  input  logic [GRAN_HI-1:0] req_gran,
  input  logic               clr_all,
  output logic               hit,
  output logic               wrap
);
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic               flag;
  logic [GRAN_HI-1:0] rgran;
  logic [PH_W-1:0]    phase;
  logic               fail;

  assign hit  = flag && (rgran == req_gran);
  assign fail = sel && (op == OP_SC) && !hit;
  assign wrap = fail && (phase == PH_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      rgran <= '0;
      phase <= '0;
    end else begin
      if (sel && op == OP_LOCK) begin
        flag  <= 1'b1;
        rgran <= req_gran;
      end else if (fail || (clr_all && hit)) begin
        flag  <= 1'b0;
      end
      if (fail)
        phase <= wrap ? '0 : phase + 1'b1;
      else if (sel && (op == OP_SC || op == OP_SC_UC))
        phase <= '0;
    end
  end
endmodule

// File: rtl/resv_out.sv
module resv_out
  import resv_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  resv_op_e           op,
  input  logic               own_hit,
  input  logic [NUM_CTX-1:0] wrap_vec,
  input  logic [CTX_W-1:0]   ctx,
  output logic               res_valid,
  output logic               res_success,
  output logic               warn_pulse,
  output logic [CTX_W-1:0]   warn_ctx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_success <= 1'b0;
      warn_pulse  <= 1'b0;
      warn_ctx    <= '0;
    end else begin
      res_valid   <= (op == OP_SC);
      res_success <= (op == OP_SC) && own_hit;
      warn_pulse  <= |wrap_vec;
      if (|wrap_vec) warn_ctx <= ctx;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN        = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_store,
  input  logic              req_locked,
  input  logic              req_uncached,
  output logic              res_valid,
  output logic              res_success,
  output logic              warn_pulse,
  output logic [CTX_W-1:0]  warn_ctx
);
  localparam int GRAN_HI = ADDR_W - GRAN;

  resv_op_e           op;
  logic [NUM_CTX-1:0] hit_vec;
  logic [NUM_CTX-1:0] wrap_vec;
  logic               own_hit;
  logic               clr_all;
  logic               unused_ofs;

  assign unused_ofs = ^req_addr[GRAN-1:0];

  resv_decode u_dec (
    .valid(req_valid), .store(req_store), .locked(req_locked),
    .uncached(req_uncached), .op(op)
  );

  always_comb begin
    own_hit = 1'b0;
    for (int k = 0; k < NUM_CTX; k++)
      if (req_ctx == CTX_W'(k)) own_hit = hit_vec[k];
  end

  assign clr_all = (op == OP_STORE) || (op == OP_SC_UC) || (op == OP_SC && own_hit);

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
    resv_slot #(.GRAN_HI(GRAN_HI), .PERIOD(WARN_PERIOD)) u_slot (
      .clk(clk), .rst(rst),
      .sel(req_ctx == CTX_W'(i)),
      .op(op),
      .req_gran(req_addr[ADDR_W-1:GRAN]),
      .clr_all(clr_all),
      .hit(hit_vec[i]),
      .wrap(wrap_vec[i])
    );
  end

  resv_out #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_out (
    .clk(clk), .rst(rst), .op(op), .own_hit(own_hit), .wrap_vec(wrap_vec),
    .ctx(req_ctx), .res_valid(res_valid), .res_success(res_success),
    .warn_pulse(warn_pulse), .warn_ctx(warn_ctx)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  parameter int GRAN    = 4,
  parameter int CTX_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [CTX_W-1:0]  req_ctx,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_store,
  input logic              req_locked,
  input logic              req_uncached,
  input logic              res_valid,
  input logic              res_success,
  input logic              warn_pulse,
  input logic [CTX_W-1:0]  warn_ctx
);
  // R3: a result follows only a cacheable conditional store
  assert_result_source_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid && req_store && req_locked && !req_uncached));

  // R3: success is never reported without a result
  assert_success_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    res_success |-> res_valid);

  // R2: locked load followed by same-granule conditional store succeeds
  assert_lock_then_sc_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store && req_locked) ##1
    (req_valid && req_store && req_locked && !req_uncached &&
     req_ctx == $past(req_ctx) &&
     req_addr[ADDR_W-1:GRAN] == $past(req_addr[ADDR_W-1:GRAN]))
    |=> res_success);

  // R6: uncacheable conditional store yields no result
  assert_uncached_no_result_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && req_locked && req_uncached) |=> !res_valid);

  // R7: warning accompanies a failed result and names the issuer
  assert_warn_on_failure_R7: assert property (@(posedge clk) disable iff (rst)
    warn_pulse |-> (res_valid && !res_success && warn_ctx == $past(req_ctx)));

  // R8: idle cycles give no result
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid && !warn_pulse);
endmodule

bind resv_monitor resv_monitor_chk #(
  .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .GRAN(GRAN), .CTX_W(CTX_W)
) u_chk (.*);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
  localparam int NC = 4;
  localparam int AW = 32;
  localparam int PER = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_ctx = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_store = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
  logic res_valid, res_success, warn_pulse;
  logic [1:0] warn_ctx;

  always #2 clk = ~clk;

  resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN(4), .WARN_PERIOD(PER)) u_resv_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_store(req_store), .req_locked(req_locked),
    .req_uncached(req_uncached), .res_valid(res_valid),
    .res_success(res_success), .warn_pulse(warn_pulse), .warn_ctx(warn_ctx)
  );

  int vectors = 0;
  int miscompares = 0;
  bit mflag [NC];
  logic [AW-1:0] maddr [NC];
  int mcnt [NC];
  bit ev, es, ew;
  int ec;

  task automatic cmp(string rq);
    vectors++;
    if (res_valid !== ev || res_success !== es || warn_pulse !== ew ||
        (ew && warn_ctx !== 2'(ec))) begin
      miscompares++;
      $display("FAIL %s: got v=%0b s=%0b w=%0b c=%0d, expected v=%0b s=%0b w=%0b c=%0d",
               rq, res_valid, res_success, warn_pulse, warn_ctx, ev, es, ew, ec);
    end
  endtask

  task automatic model(bit v, int c, logic [AW-1:0] a, bit st, bit lk, bit uc);
    bit hit, clr;
    ev = 0; es = 0; ew = 0; clr = 0;
    if (!v) return;
    hit = mflag[c] && (maddr[c][AW-1:4] == a[AW-1:4]);
    if (!st && lk) begin
      mflag[c] = 1; maddr[c] = a;
    end else if (st) begin
      if (lk && uc) begin
        mcnt[c] = 0; clr = 1;
      end else if (lk) begin
        ev = 1; es = hit;
        if (hit) begin mcnt[c] = 0; clr = 1; end
        else begin
          mflag[c] = 0; mcnt[c]++;
          if (mcnt[c] % PER == 0) begin ew = 1; ec = c; end
        end
      end else clr = 1;
      if (clr)
        for (int k = 0; k < NC; k++)
          if (mflag[k] && maddr[k][AW-1:4] == a[AW-1:4]) mflag[k] = 0;
    end
  endtask

  task automatic apply(string rq, bit v, int c, logic [AW-1:0] a, bit st, bit lk, bit uc);
    req_valid = v; req_ctx = 2'(c); req_addr = a;
    req_store = st; req_locked = lk; req_uncached = uc;
    @(posedge clk);
    model(v, c, a, st, lk, uc);
    @(negedge clk);
    cmp(rq);
  endtask

  task automatic ll(string rq, int c, logic [AW-1:0] a); apply(rq, 1, c, a, 0, 1, 0); endtask
  task automatic sc(string rq, int c, logic [AW-1:0] a); apply(rq, 1, c, a, 1, 1, 0); endtask
  task automatic st(string rq, int c, logic [AW-1:0] a); apply(rq, 1, c, a, 1, 0, 0); endtask
  task automatic scu(string rq, int c, logic [AW-1:0] a); apply(rq, 1, c, a, 1, 1, 1); endtask
  task automatic idle(string rq); apply(rq, 0, 0, '0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin mflag[k] = 0; maddr[k] = '0; mcnt[k] = 0; end
    ev = 0; es = 0; ew = 0; ec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cmp("R1 reset outputs");
    for (int k = 0; k < NC; k++) sc("R1 no reservation after reset", k, 32'h100);

    // R2 / R3: reserve then succeed within same granule, then fail (cleared)
    ll("R2 lock", 0, 32'h100);
    sc("R3 same granule success", 0, 32'h108);
    sc("R5 issuer cleared by own success", 0, 32'h100);
    ll("R2 lock", 0, 32'h200);
    sc("R3 neighbouring granule fails", 0, 32'h210);

    // R5: ordinary store clears matching reservations only
    ll("R2 lock", 1, 32'h300);
    ll("R2 lock", 2, 32'h310);
    st("R5 plain store", 3, 32'h304);
    sc("R5 matching cleared", 1, 32'h300);
    sc("R5 other granule kept", 2, 32'h310);

    // R4: failing SC clears only issuer
    ll("R2 lock", 0, 32'h400);
    ll("R2 lock", 1, 32'h400);
    sc("R4 mismatch fail", 0, 32'h500);
    sc("R4 issuer cleared", 0, 32'h400);
    sc("R4 other context kept", 1, 32'h400);

    // R8: loads and idle change nothing
    ll("R2 lock", 3, 32'h600);
    apply("R8 plain load", 1, 3, 32'h600, 0, 0, 0);
    apply("R8 plain load other", 1, 2, 32'h604, 0, 0, 0);
    idle("R8 idle");
    idle("R8 idle");
    sc("R8 reservation survives", 3, 32'h60c);

    // R6: uncached SC clears matching and gives no result
    ll("R2 lock", 2, 32'h700);
    ll("R2 lock", 3, 32'h700);
    scu("R6 uncached no result", 2, 32'h700);
    sc("R6 uncached cleared others", 3, 32'h700);

    // R7 / R6 / R9: failure streaks
    for (int i = 0; i < PER - 1; i++) sc("R7 streak ctx1", 1, 32'h800);
    scu("R6 uncached resets count", 1, 32'h900);
    for (int i = 0; i < PER - 1; i++) begin
      sc("R6 no early warning", 1, 32'h800);
      sc("R9 interleaved ctx2", 2, 32'h800);
    end
    sc("R7 warning at period", 1, 32'h800);
    sc("R9 ctx2 reaches period", 2, 32'h800);
    for (int i = 0; i < PER - 1; i++) sc("R7 second streak", 1, 32'h800);
    sc("R7 second warning", 1, 32'h800);
    for (int i = 0; i < PER - 2; i++) sc("R7 streak ctx0", 0, 32'hA00);
    ll("R2 lock", 0, 32'hA00);
    sc("R7 success resets", 0, 32'hA00);
    for (int i = 0; i < PER - 1; i++) sc("R7 no warning after success", 0, 32'hA00);
    sc("R7 warning ctx0", 0, 32'hA00);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int c, sel;
      logic [AW-1:0] a;
      c = $urandom % NC;
      a = 32'h1000 + 32'(($urandom % 3) * 16) + 32'($urandom % 16);
      sel = $urandom % 10;
      if (sel < 4)       ll("R2 random", c, a);
      else if (sel < 7)  sc("R3 random", c, a);
      else if (sel == 7) st("R5 random", c, a);
      else if (sel == 8) scu("R6 random", c, a);
      else               idle("R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule